// File: doc/BRIEF.md
# Issue-Window Register Occupancy Matrix

This block tracks which physical registers are still needed by a processor whose issue window dispatches instructions in random order. It keeps one bit row per issue-window slot and one extra row for the registers that currently back a virtual register. A bit at row i, column p means that slot i (or the current mapping, for the extra row) refers to physical register p. The column-wise OR of all rows gives a per-register busy vector. The random free-register picker of the renamer reads that vector.

Three command groups drive the matrix, and all of them can act in the same clock cycle:
- A **slot fill** writes a new instruction's operand set into one row.
- A **slot completion** wipes one row.
- A **remap** sets the bit of the register newly bound to a virtual register in the extra row and drops the bit of the register it releases.

Every command is a plain strobe. Each strobe takes effect at the next rising clock edge. The block never applies back-pressure, so no ready signal exists.

Top module: `regusage_matrix`

## Requirements
- R1: After reset all slot rows are empty. The mapping row holds the identity binding, so `busy_vec` has exactly bits 0 to 2^VIRT_W-1 set. With the defaults this is 16'h00FF.
- R2: A fill to slot E loads row E with one bit for each enabled operand: first source, second source and destination, each with its own enable. A disabled operand contributes no bit, whatever its register field holds.
- R3: A fill replaces the previous content of the row. Bits left over from an earlier instruction in that slot do not survive the fill.
- R4: A completion of slot C clears every bit of row C.
- R5: When a fill and a completion name the same slot in the same cycle, the fill wins and the row holds the new operand set.
- R6: A fill and a completion that name different slots in the same cycle both take effect.
- R7: `busy_vec[r]` is 1 exactly when some slot row or the mapping row holds bit r. A register stays busy until every row that refers to it has dropped it.
- R8: A remap sets bit `map_new` of the mapping row. In the same cycle it clears bit `map_old` when `map_release` is high. Without `map_en` the mapping row does not change.
- R9: A remap whose released register equals its new register leaves that register mapped, because the set wins.
- R10: `busy_vec` is taken from registered state. A command applied before a rising edge shows on `busy_vec` right after that edge and not before it.
- R11: A fill or completion whose slot index is SLOTS or larger is ignored. No row changes, and any valid command in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | Write a new instruction into a slot |
| fill_slot | input | SLOT_W | Slot to be filled |
| fill_src0 | input | PHYS_W | First source physical register |
| fill_src0_en | input | 1 | First source is present |
| fill_src1 | input | PHYS_W | Second source physical register |
| fill_src1_en | input | 1 | Second source is present |
| fill_dst | input | PHYS_W | Destination physical register |
| fill_dst_en | input | 1 | Destination is present |
| done_en | input | 1 | An instruction in a slot has completed |
| done_slot | input | SLOT_W | Slot that completed |
| map_en | input | 1 | Renamer has bound a new physical register |
| map_new | input | PHYS_W | Newly bound physical register |
| map_release | input | 1 | Previous binding is released in the same cycle |
| map_old | input | PHYS_W | Released physical register |
| busy_vec | output | 2^PHYS_W | Per-register in-use vector, column OR of all rows |

## Verification
A fill and a completion can fall in the same cycle, and the hard case is when both name the same slot. The bench drives both strobes before one edge with equal slot indices and expects only the new operand bits on `busy_vec`. It repeats the pair with different slots and expects the fill to appear while the other row's bits vanish. A remap and a slot row can also touch the same register in the same cycle. In that case the bench releases a register that a slot still reads, and checks that its bit stays up until the slot completes.

// File: rtl/regusage_pkg.sv
package regusage_pkg;

  // Action applied to one slot row in a cycle.
  typedef enum logic [1:0] {
    ROW_HOLD  = 2'd0,
    ROW_LOAD  = 2'd1,
    ROW_CLEAR = 2'd2
  } row_op_e;

  // A fill to a row outranks a completion of the same row.
  function automatic row_op_e pick_row_op(input logic fill_hit, input logic done_hit);
    if (fill_hit)      return ROW_LOAD;
    else if (done_hit) return ROW_CLEAR;
    else               return ROW_HOLD;
  endfunction

endpackage

// File: rtl/ru_operand_decode.sv
module ru_operand_decode #(
  parameter int PHYS_W = 4,
  localparam int NREG  = 1 << PHYS_W
) (
  input  logic [PHYS_W-1:0] src0,
  input  logic              src0_en,
  input  logic [PHYS_W-1:0] src1,
  input  logic              src1_en,
  input  logic [PHYS_W-1:0] dst,
  input  logic              dst_en,
  output logic [NREG-1:0]   mask
);

  always_comb begin
    mask = '0;
    if (src0_en) mask[src0] = 1'b1;
    if (src1_en) mask[src1] = 1'b1;
    if (dst_en)  mask[dst]  = 1'b1;
  end

endmodule

// File: rtl/ru_slot_row.sv
module ru_slot_row
  import regusage_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  row_op_e         op,
  input  logic [NREG-1:0] load_mask,
  output logic [NREG-1:0] row_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      case (op)
        ROW_LOAD:  row_q <= load_mask;
        ROW_CLEAR: row_q <= '0;
        default:   row_q <= row_q;
      endcase
    end
  end

  assert_row_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROW_LOAD) |=> (row_q == $past(load_mask)));

  assert_row_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROW_CLEAR) |=> (row_q == '0));

  assert_row_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROW_HOLD) |=> $stable(row_q));

endmodule

// File: rtl/ru_map_row.sv
module ru_map_row #(
  parameter int PHYS_W = 4,
  parameter int VIRT_W = 3,
  localparam int NREG  = 1 << PHYS_W,
  localparam int NVIRT = 1 << VIRT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_en,
  input  logic [PHYS_W-1:0] map_new,
  input  logic              map_release,
  input  logic [PHYS_W-1:0] map_old,
  output logic [NREG-1:0]   map_q
);

  localparam logic [NREG-1:0] IDENT = {{(NREG-NVIRT){1'b0}}, {NVIRT{1'b1}}};

  logic [NREG-1:0] map_d;

  always_comb begin
    map_d = map_q;
    if (map_en) begin
      if (map_release) map_d[map_old] = 1'b0;
      map_d[map_new] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= IDENT;
    else        map_q <= map_d;
  end

  assert_map_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_en |=> map_q[$past(map_new)]);

  assert_map_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en && map_release && (map_old != map_new)) |=> !map_q[$past(map_old)]);

  assert_map_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |=> $stable(map_q));

endmodule

// File: rtl/ru_column_or.sv
module ru_column_or #(
  parameter int ROWS = 7,
  parameter int NREG = 16
) (
  input  logic [ROWS-1:0][NREG-1:0] rows,
  output logic [NREG-1:0]           busy
);

  for (genvar c = 0; c < NREG; c++) begin : g_col
    logic [ROWS-1:0] column;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign column[r] = rows[r][c];
    end
    assign busy[c] = |column;
  end

endmodule

// File: rtl/regusage_matrix.sv
module regusage_matrix
  import regusage_pkg::*;
#(
  parameter int SLOTS  = 6,
  parameter int PHYS_W = 4,
  parameter int VIRT_W = 3,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NREG   = 1 << PHYS_W,
  localparam int ROWS   = SLOTS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic [PHYS_W-1:0] fill_src0,
  input  logic              fill_src0_en,
  input  logic [PHYS_W-1:0] fill_src1,
  input  logic              fill_src1_en,
  input  logic [PHYS_W-1:0] fill_dst,
  input  logic              fill_dst_en,
  input  logic              done_en,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic              map_en,
  input  logic [PHYS_W-1:0] map_new,
  input  logic              map_release,
  input  logic [PHYS_W-1:0] map_old,
  output logic [NREG-1:0]   busy_vec
);

  logic [NREG-1:0]           fill_mask;
  logic [ROWS-1:0][NREG-1:0] all_rows;

  ru_operand_decode #(.PHYS_W(PHYS_W)) u_decode (
    .src0    (fill_src0),
    .src0_en (fill_src0_en),
    .src1    (fill_src1),
    .src1_en (fill_src1_en),
    .dst     (fill_dst),
    .dst_en  (fill_dst_en),
    .mask    (fill_mask)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(k);
    row_op_e op;
    assign op = pick_row_op(fill_en && (fill_slot == IDX),
                            done_en && (done_slot == IDX));
    ru_slot_row #(.NREG(NREG)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .load_mask (fill_mask),
      .row_q     (all_rows[k])
    );
  end

  ru_map_row #(.PHYS_W(PHYS_W), .VIRT_W(VIRT_W)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_en      (map_en),
    .map_new     (map_new),
    .map_release (map_release),
    .map_old     (map_old),
    .map_q       (all_rows[SLOTS])
  );

  ru_column_or #(.ROWS(ROWS), .NREG(NREG)) u_or (
    .rows (all_rows),
    .busy (busy_vec)
  );

  // A fill that collides with a completion of the same slot must still show.
  assert_fill_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && done_en && (fill_slot == done_slot) && (int'(fill_slot) < SLOTS))
    |=> ((busy_vec & $past(fill_mask)) == $past(fill_mask)));

  // The mapping row is always reflected in the busy vector.
  assert_busy_covers_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_vec & all_rows[SLOTS]) == all_rows[SLOTS]));

endmodule

// File: tb/tb_regusage_matrix.sv
module tb_regusage_matrix;

  localparam int SLOTS  = 6;
  localparam int PHYS_W = 4;
  localparam int VIRT_W = 3;
  localparam int SLOT_W = 3;
  localparam int NREG   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fill_en, fill_src0_en, fill_src1_en, fill_dst_en;
  logic [SLOT_W-1:0] fill_slot, done_slot;
  logic [PHYS_W-1:0] fill_src0, fill_src1, fill_dst, map_new, map_old;
  logic              done_en, map_en, map_release;
  logic [NREG-1:0]   busy_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  regusage_matrix #(.SLOTS(SLOTS), .PHYS_W(PHYS_W), .VIRT_W(VIRT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_slot(fill_slot),
    .fill_src0(fill_src0), .fill_src0_en(fill_src0_en),
    .fill_src1(fill_src1), .fill_src1_en(fill_src1_en),
    .fill_dst(fill_dst), .fill_dst_en(fill_dst_en),
    .done_en(done_en), .done_slot(done_slot),
    .map_en(map_en), .map_new(map_new),
    .map_release(map_release), .map_old(map_old),
    .busy_vec(busy_vec)
  );

  task automatic check(input string req, input logic [NREG-1:0] exp);
    n_chk++;
    if (busy_vec !== exp) begin
      n_bad++;
      $display("FAIL %s busy_vec actual=%h expected=%h", req, busy_vec, exp);
    end
  endtask

  task automatic idle();
    fill_en = 0; fill_slot = '0; fill_src0 = '0; fill_src0_en = 0;
    fill_src1 = '0; fill_src1_en = 0; fill_dst = '0; fill_dst_en = 0;
    done_en = 0; done_slot = '0; map_en = 0; map_new = '0;
    map_release = 0; map_old = '0;
  endtask

  task automatic set_fill(input int slot, input int s0, input bit e0,
                          input int s1, input bit e1, input int d, input bit ed);
    fill_en = 1; fill_slot = SLOT_W'(slot);
    fill_src0 = PHYS_W'(s0); fill_src0_en = e0;
    fill_src1 = PHYS_W'(s1); fill_src1_en = e1;
    fill_dst = PHYS_W'(d); fill_dst_en = ed;
  endtask

  task automatic set_done(input int slot);
    done_en = 1; done_slot = SLOT_W'(slot);
  endtask

  task automatic set_map(input int nw, input bit rel, input int od);
    map_en = 1; map_new = PHYS_W'(nw); map_release = rel; map_old = PHYS_W'(od);
  endtask

  // Commands are set at a falling edge, applied at the rising edge,
  // and the result is sampled at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    check("R1 reset identity", 16'h00FF);
    step(); step();
    check("R10 idle keeps state", 16'h00FF);
  endtask

  task automatic t_fill();
    set_fill(0, 9, 1, 10, 1, 11, 1);
    #1 check("R10 no change before edge", 16'h00FF);
    step();
    check("R2 all operands", 16'h0EFF);
    set_fill(1, 13, 0, 14, 0, 12, 1);
    step();
    check("R2 disabled sources ignored", 16'h1EFF);
  endtask

  task automatic t_done_replace();
    set_done(0); step();
    check("R4 completion clears row", 16'h10FF);
    set_fill(1, 0, 0, 0, 0, 13, 1); step();
    check("R3 fill replaces row", 16'h20FF);
  endtask

  task automatic t_overlap();
    set_fill(2, 14, 1, 0, 0, 13, 1); step();
    check("R7 shared column", 16'h60FF);
    set_done(1); step();
    check("R7 still held by other slot", 16'h60FF);
    set_done(2); step();
    check("R7 released by last holder", 16'h00FF);
  endtask

  task automatic t_collide();
    set_fill(3, 9, 1, 0, 0, 0, 0); set_done(3); step();
    check("R5 fill beats completion", 16'h02FF);
    set_done(3); step();
    check("R4 collided row cleared", 16'h00FF);
    set_fill(4, 0, 0, 0, 0, 10, 1); step();
    set_fill(5, 0, 0, 0, 0, 11, 1); set_done(4); step();
    check("R6 fill and completion on two slots", 16'h08FF);
    set_done(5); step();
    check("R6 cleanup", 16'h00FF);
  endtask

  task automatic t_map();
    set_map(15, 1, 3); step();
    check("R8 remap set and release", 16'h80F7);
    set_map(3, 1, 15); step();
    check("R8 remap back", 16'h00FF);
    set_map(5, 1, 5); step();
    check("R9 same register stays mapped", 16'h00FF);
    set_fill(0, 2, 1, 0, 0, 0, 0); step();
    set_map(12, 1, 2); step();
    check("R7 released reg held by slot", 16'h10FF);
    set_done(0); step();
    check("R7 released reg freed", 16'h10FB);
    set_map(2, 1, 12); step();
    check("R8 restore", 16'h00FF);
  endtask

  task automatic t_range();
    set_fill(6, 0, 0, 0, 0, 15, 1); step();
    check("R11 fill to absent slot ignored", 16'h00FF);
    set_fill(0, 9, 1, 0, 0, 0, 0); step();
    set_done(7); set_map(14, 0, 0); step();
    check("R11 completion of absent slot ignored", 16'h42FF);
    set_done(0); set_map(14, 0, 0); step();
    check("R8 set without release", 16'h40FF);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_done_replace();
    t_overlap();
    t_collide();
    t_map();
    t_range();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule